// File: doc/BRIEF.md
# Single-Precision Operand and Result Modifier Stage

This stage wraps a vector ALU that works on 32-bit floating-point values. Three source operands pass through it on their way into the ALU. For each source, one control bit forces the sign to positive (absolute value) and a second bit then inverts the sign (negation). Setting both bits gives the negative of the magnitude. Only the sign bit is touched. The exponent and fraction bits pass through as they are.

The ALU result passes back through the output half of the stage. There it can be scaled by 2, 4 or one half by moving the exponent, and it can then be limited to the closed interval from 0.0 to 1.0. A bypass control marks results that are not floating-point values, for example a bitwise conditional select. Such a result leaves the stage exactly as it arrived, whatever the scaling and clamp controls say.

The stage is combinational. When the parameter `OUT_REG` is 1, all four outputs are registered and take effect one cycle later.

Top module: `fp_mod_stage`

## Requirements
- R1: When a source's absolute-value bit is set and its negate bit is clear, that source's output has sign bit 31 equal to 0.
- R2: Negation inverts the sign bit after the absolute value has been applied. With both bits set the output sign is 1, and with only the negate bit set the output sign is the inverse of the input sign.
- R3: Bits 30:0 of every source output equal bits 30:0 of the matching source input.
- R4: The scale field `omod_i` is encoded as 0 = none, 1 = ×2, 2 = ×4, 3 = ×0.5. With field 0 and clamp off, the result output equals the result input bit for bit, and this includes denormal inputs.
- R5: For a normal input, ×2 adds 1 and ×4 adds 2 to the 8-bit exponent field (bits 30:23). If the new exponent reaches 255 or more, the output is an infinity with the input's sign.
- R6: For a normal input, ×0.5 subtracts 1 from the exponent. An input with exponent field 1 becomes a zero with the input's sign.
- R7: Under any nonzero scale code, an input with exponent field 0 (a zero or a denormal) becomes a zero with the input's sign.
- R8: Under any scale code, an input with exponent field 255 (an infinity or a NaN) passes through unchanged.
- R9: When clamp is on, a NaN becomes +0.0 (0x00000000). Any value with sign 1, including -0.0 and -infinity, becomes +0.0. A positive value above 1.0, including +infinity, becomes 1.0 (0x3F800000). Any other value is unchanged.
- R10: Scaling is applied before the clamp. For example, 4.0 with ×0.5 and clamp gives 1.0, not 0.5.
- R11: When bypass is set, the result output equals the result input, whatever `omod_i` and `clamp_i` are.
- R12: With `OUT_REG`=1, every output holds 0 during reset. Afterwards each output shows the value computed from the inputs present at the previous rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock (used only when OUT_REG=1 and by assertions) |
| rst_n | input | 1 | Active-low reset of the output register |
| src0_i | input | 32 | Source operand 0 |
| src1_i | input | 32 | Source operand 1 |
| src2_i | input | 32 | Source operand 2 |
| abs_i | input | 3 | Absolute-value control, bit k for source k |
| neg_i | input | 3 | Negate control, bit k for source k |
| res_i | input | 32 | ALU result to modify |
| omod_i | input | 2 | Output scale code |
| clamp_i | input | 1 | Limit the result to [0.0, 1.0] |
| bypass_i | input | 1 | Pass the result through untouched |
| src0_o | output | 32 | Modified source 0 |
| src1_o | output | 32 | Modified source 1 |
| src2_o | output | 32 | Modified source 2 |
| res_o | output | 32 | Modified result |

## Verification
The stage keeps no state beyond the optional output register. A fault in the modifier logic therefore shows up on the outputs in the same cycle as the inputs that trigger it, or one cycle later when the register is present. A wrong exponent step, or a missed test for a special value, only shows for particular exponent fields: 0, 1, 253, 254 and 255, and the values next to 1.0. For that reason the random stimulus is weighted toward those fields, alongside directed cases for each special value. A register that failed to capture, or that reset to a nonzero value, is caught by comparing the registered instance against the values predicted from the inputs of the previous cycle.

// File: rtl/fp_mod_stage.sv
module fp_mod_stage #(
  parameter int EXP_W   = 8,
  parameter int MAN_W   = 23,
  parameter bit OUT_REG = 1'b0
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [EXP_W+MAN_W:0]       src0_i,
  input  logic [EXP_W+MAN_W:0]       src1_i,
  input  logic [EXP_W+MAN_W:0]       src2_i,
  input  logic [2:0]                 abs_i,
  input  logic [2:0]                 neg_i,
  input  logic [EXP_W+MAN_W:0]       res_i,
  input  logic [1:0]                 omod_i,
  input  logic                       clamp_i,
  input  logic                       bypass_i,
  output logic [EXP_W+MAN_W:0]       src0_o,
  output logic [EXP_W+MAN_W:0]       src1_o,
  output logic [EXP_W+MAN_W:0]       src2_o,
  output logic [EXP_W+MAN_W:0]       res_o
);
  localparam int W    = EXP_W + MAN_W + 1;
  localparam int NSRC = 3;
  localparam logic [EXP_W-1:0] EMAX = '1;
  localparam logic [EXP_W-1:0] BIAS = {1'b0, {(EXP_W-1){1'b1}}};
  localparam logic [W-2:0]     ONE_MAG = {BIAS, {MAN_W{1'b0}}};

  logic [W-1:0] src_in [NSRC];
  logic [W-1:0] src_md [NSRC];

  assign src_in[0] = src0_i;
  assign src_in[1] = src1_i;
  assign src_in[2] = src2_i;

  for (genvar k = 0; k < NSRC; k++) begin : g_src
    wire sgn_abs = abs_i[k] ? 1'b0 : src_in[k][W-1];
    assign src_md[k] = {sgn_abs ^ neg_i[k], src_in[k][W-2:0]};

    a_r2_abs_neg_sign: assert property (@(posedge clk) disable iff (!rst_n)
      (abs_i[k] && neg_i[k]) |-> src_md[k][W-1]);
    a_r1_abs_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (abs_i[k] && !neg_i[k]) |-> !src_md[k][W-1]);
    a_r3_mag_kept: assert property (@(posedge clk) disable iff (!rst_n)
      src_md[k][W-2:0] == src_in[k][W-2:0]);
  end

  wire               r_sgn = res_i[W-1];
  wire [EXP_W-1:0]   r_exp = res_i[W-2:MAN_W];
  wire [MAN_W-1:0]   r_man = res_i[MAN_W-1:0];
  logic [EXP_W:0]    exp_up;
  logic [W-1:0]      scaled;
  logic [W-1:0]      clamped;
  logic [W-1:0]      res_c;

  assign exp_up = {1'b0, r_exp} + ((omod_i == 2'd2) ? (EXP_W+1)'(2) : (EXP_W+1)'(1));

  always_comb begin
    scaled = res_i;
    if (omod_i != 2'd0 && r_exp != EMAX) begin
      if (r_exp == '0)
        scaled = {r_sgn, {(W-1){1'b0}}};
      else if (omod_i == 2'd3)
        scaled = (r_exp == EXP_W'(1)) ? {r_sgn, {(W-1){1'b0}}}
                                      : {r_sgn, r_exp - EXP_W'(1), r_man};
      else if (exp_up >= {1'b0, EMAX})
        scaled = {r_sgn, EMAX, {MAN_W{1'b0}}};
      else
        scaled = {r_sgn, exp_up[EXP_W-1:0], r_man};
    end
  end

  wire s_nan = (scaled[W-2:MAN_W] == EMAX) && (scaled[MAN_W-1:0] != '0);

  always_comb begin
    clamped = scaled;
    if (s_nan || scaled[W-1])
      clamped = '0;
    else if (scaled[W-2:0] > ONE_MAG)
      clamped = {1'b0, ONE_MAG};
  end

  assign res_c = bypass_i ? res_i : (clamp_i ? clamped : scaled);

  a_r11_bypass_exact: assert property (@(posedge clk) disable iff (!rst_n)
    bypass_i |-> res_c == res_i);
  a_r9_clamp_range: assert property (@(posedge clk) disable iff (!rst_n)
    (clamp_i && !bypass_i) |-> (!res_c[W-1] && res_c[W-2:0] <= ONE_MAG));
  a_r8_special_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (!clamp_i && r_exp == EMAX) |-> res_c == res_i);
  a_r4_no_scale_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (!clamp_i && omod_i == 2'd0) |-> res_c == res_i);

  if (OUT_REG) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        src0_o <= '0;
        src1_o <= '0;
        src2_o <= '0;
        res_o  <= '0;
      end else begin
        src0_o <= src_md[0];
        src1_o <= src_md[1];
        src2_o <= src_md[2];
        res_o  <= res_c;
      end
    end

    a_r12_reg_follows: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> res_o == $past(res_c));
  end else begin : g_comb
    assign src0_o = src_md[0];
    assign src1_o = src_md[1];
    assign src2_o = src_md[2];
    assign res_o  = res_c;
  end
endmodule

// File: tb/fp_mod_stage_bench.sv
`timescale 1ns/1ps
module fp_mod_stage_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [31:0] s0 = '0, s1 = '0, s2 = '0, r = '0;
  logic [2:0]  ab = '0, ng = '0;
  logic [1:0]  om = '0;
  logic        cl = 1'b0, by = 1'b0;
  logic [31:0] c_s0, c_s1, c_s2, c_r;
  logic [31:0] q_s0, q_s1, q_s2, q_r;
  int checks = 0, errors = 0;
  bit done = 1'b0;
  bit prev_ok = 1'b0;
  logic [31:0] p_s0, p_s1, p_s2, p_r;

  always #10 clk = ~clk;

  fp_mod_stage u_fp_mod_stage (
    .clk(clk), .rst_n(rst_n), .src0_i(s0), .src1_i(s1), .src2_i(s2),
    .abs_i(ab), .neg_i(ng), .res_i(r), .omod_i(om), .clamp_i(cl), .bypass_i(by),
    .src0_o(c_s0), .src1_o(c_s1), .src2_o(c_s2), .res_o(c_r));

  fp_mod_stage #(.OUT_REG(1'b1)) u_fp_mod_stage_q (
    .clk(clk), .rst_n(rst_n), .src0_i(s0), .src1_i(s1), .src2_i(s2),
    .abs_i(ab), .neg_i(ng), .res_i(r), .omod_i(om), .clamp_i(cl), .bypass_i(by),
    .src0_o(q_s0), .src1_o(q_s1), .src2_o(q_s2), .res_o(q_r));

  function automatic logic [31:0] m_src(input logic [31:0] x, input logic a, input logic n);
    logic sg;
    sg = a ? 1'b0 : x[31];
    if (n) sg = ~sg;
    return {sg, x[30:0]};
  endfunction

  function automatic logic [31:0] m_res(input logic [31:0] x, input logic [1:0] o,
                                        input logic c, input logic b);
    int e;
    logic [31:0] y;
    if (b) return x;
    e = int'(x[30:23]);
    y = x;
    if (o != 0 && e != 255) begin
      if (e == 0) y = {x[31], 31'd0};
      else begin
        e = e + ((o == 1) ? 1 : (o == 2) ? 2 : -1);
        if (e >= 255)     y = {x[31], 8'hFF, 23'd0};
        else if (e <= 0)  y = {x[31], 31'd0};
        else              y = {x[31], 8'(e), x[22:0]};
      end
    end
    if (c) begin
      if (y[30:23] == 8'hFF && y[22:0] != 0) y = 32'h0;
      else if (y[31])                        y = 32'h0;
      else if (y > 32'h3F80_0000)            y = 32'h3F80_0000;
    end
    return y;
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic drive(input string tag, input logic [31:0] a0, input logic [31:0] a1,
                       input logic [31:0] a2, input logic [2:0] fa, input logic [2:0] fn,
                       input logic [31:0] rr, input logic [1:0] o, input logic c, input logic b);
    @(negedge clk);
    if (prev_ok) begin
      chk("R12 reg src0", q_s0, p_s0);
      chk("R12 reg src1", q_s1, p_s1);
      chk("R12 reg src2", q_s2, p_s2);
      chk("R12 reg res",  q_r,  p_r);
    end
    s0 = a0; s1 = a1; s2 = a2; ab = fa; ng = fn; r = rr; om = o; cl = c; by = b;
    p_s0 = m_src(a0, fa[0], fn[0]);
    p_s1 = m_src(a1, fa[1], fn[1]);
    p_s2 = m_src(a2, fa[2], fn[2]);
    p_r  = m_res(rr, o, c, b);
    prev_ok = 1'b1;
    #1;
    chk({tag, " src0"}, c_s0, p_s0);
    chk({tag, " src1"}, c_s1, p_s1);
    chk({tag, " src2"}, c_s2, p_s2);
    chk({tag, " res"},  c_r,  p_r);
  endtask

  function automatic logic [31:0] pick_val();
    logic [31:0] v;
    v = $urandom;
    case ($urandom % 8)
      0: v[30:23] = 8'd0;
      1: v[30:23] = 8'd255;
      2: v[30:23] = 8'd253 + 8'($urandom % 2);
      3: v[30:23] = 8'd1 + 8'($urandom % 2);
      4: v[30:23] = 8'd126 + 8'($urandom % 2);
      5: v = {v[31], 31'h3F80_0000};
      default: ;
    endcase
    return v;
  endfunction

  initial begin
    #(20ns * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk("R12 reset src0", q_s0, 32'h0);
    chk("R12 reset src1", q_s1, 32'h0);
    chk("R12 reset src2", q_s2, 32'h0);
    chk("R12 reset res",  q_r,  32'h0);
    rst_n = 1'b1;
    p_s0 = '0; p_s1 = '0; p_s2 = '0; p_r = '0;
    prev_ok = 1'b1;

    drive("R1", 32'hC000_0000, 32'h4000_0000, 32'h8000_0000, 3'b111, 3'b000, 0, 0, 0, 0);
    chk("R1 abs src0", c_s0, 32'h4000_0000);
    drive("R2", 32'h4000_0000, 32'hC000_0000, 32'h3F80_0000, 3'b001, 3'b111, 0, 0, 0, 0);
    chk("R2 abs+neg", c_s0, 32'hC000_0000);
    chk("R2 neg only", c_s1, 32'h4000_0000);
    drive("R3", 32'hFFFF_FFFF, 32'h7FFF_FFFF, 32'h1234_5678, 3'b010, 3'b100, 0, 0, 0, 0);
    chk("R3 mag src2", c_s2, 32'h9234_5678);

    drive("R4", 0, 0, 0, 0, 0, 32'h0000_0001, 2'd0, 0, 0);
    chk("R4 denorm kept", c_r, 32'h0000_0001);
    drive("R5", 0, 0, 0, 0, 0, 32'h3FC0_0000, 2'd1, 0, 0);
    chk("R5 x2", c_r, 32'h4040_0000);
    drive("R5", 0, 0, 0, 0, 0, 32'h3FC0_0000, 2'd2, 0, 0);
    chk("R5 x4", c_r, 32'h40C0_0000);
    drive("R5", 0, 0, 0, 0, 0, 32'h7F7F_FFFF, 2'd1, 0, 0);
    chk("R5 overflow", c_r, 32'h7F80_0000);
    drive("R5", 0, 0, 0, 0, 0, 32'hFF7F_FFFF, 2'd2, 0, 0);
    chk("R5 neg overflow", c_r, 32'hFF80_0000);
    drive("R6", 0, 0, 0, 0, 0, 32'h3FC0_0000, 2'd3, 0, 0);
    chk("R6 half", c_r, 32'h3F40_0000);
    drive("R6", 0, 0, 0, 0, 0, 32'h8080_0000, 2'd3, 0, 0);
    chk("R6 underflow", c_r, 32'h8000_0000);
    drive("R7", 0, 0, 0, 0, 0, 32'h8000_0001, 2'd1, 0, 0);
    chk("R7 denorm flush", c_r, 32'h8000_0000);
    drive("R8", 0, 0, 0, 0, 0, 32'h7FC0_0001, 2'd2, 0, 0);
    chk("R8 nan kept", c_r, 32'h7FC0_0001);
    drive("R8", 0, 0, 0, 0, 0, 32'hFF80_0000, 2'd3, 0, 0);
    chk("R8 inf kept", c_r, 32'hFF80_0000);
    drive("R9", 0, 0, 0, 0, 0, 32'h7FC0_0001, 2'd0, 1, 0);
    chk("R9 nan", c_r, 32'h0);
    drive("R9", 0, 0, 0, 0, 0, 32'h8000_0000, 2'd0, 1, 0);
    chk("R9 neg zero", c_r, 32'h0);
    drive("R9", 0, 0, 0, 0, 0, 32'h4000_0000, 2'd0, 1, 0);
    chk("R9 above one", c_r, 32'h3F80_0000);
    drive("R9", 0, 0, 0, 0, 0, 32'h7F80_0000, 2'd0, 1, 0);
    chk("R9 inf", c_r, 32'h3F80_0000);
    drive("R9", 0, 0, 0, 0, 0, 32'h3F80_0000, 2'd0, 1, 0);
    chk("R9 one kept", c_r, 32'h3F80_0000);
    drive("R10", 0, 0, 0, 0, 0, 32'h4080_0000, 2'd3, 1, 0);
    chk("R10 scale first", c_r, 32'h3F80_0000);
    drive("R10", 0, 0, 0, 0, 0, 32'h3F40_0000, 2'd1, 1, 0);
    chk("R10 0.75x2", c_r, 32'h3F80_0000);
    drive("R11", 0, 0, 0, 0, 0, 32'hC234_5678, 2'd2, 1, 1);
    chk("R11 bypass", c_r, 32'hC234_5678);

    for (int i = 0; i < 3000; i++) begin
      drive("random", $urandom, $urandom, $urandom, 3'($urandom), 3'($urandom),
            pick_val(), 2'($urandom), 1'($urandom), ($urandom % 6) == 0);
    end
    drive("R12 flush", 0, 0, 0, 0, 0, 0, 0, 0, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule